// File: doc/BRIEF.md
# Bit Error Counter with Snapshot

This block measures the bit error rate of a serial link. Each cycle a bit may arrive together with the bit that the pattern source expected in that position. When the block is switched on it counts every bit checked and every bit that mismatched. Both live counters saturate at all-ones and do not wrap.

The live counts are never read directly. Software writes a two-bit command into the control register. The command can clear everything, freeze a copy of the counters into snapshot registers, or freeze a copy and clear the live counters in one step. That last command lets successive measurement windows be read back-to-back without losing a bit between them.

The same register port also holds two six-bit coordinates of a sample point. The horizontal one is a phase in 64 steps across 2 UI and the vertical one is a height in 64 levels. They are only stored and read back.

Top module: `ber_snapshot_counter`

## Requirements
- R1: After a synchronous reset every readable location returns 0 and both live counters are 0.
- R2: Address 0 is the control register. The command is in bits [4:3], the count-enable in bit 2, the checker-enable in bit 1 and the monitor-enable in bit 0. The three enables read back as written. The command field and bits 5 and above read as 0.
- R3: Command 1 clears the live counters and both snapshot registers.
- R4: Command 2 copies the live bit count and error count into the snapshots. A snapshot then keeps its value until the next command 1, 2 or 3.
- R5: Command 3 copies the live counts into the snapshots and clears the live counters in the same operation. The new snapshot is kept.
- R6: Command 0 changes neither the live counters nor the snapshots.
- R7: In every cycle where bit_vld is 1 and both the checker-enable and the count-enable are 1, the bit count rises by one. The error count also rises by one when bit_rx differs from bit_exp.
- R8: With count-enable at 0 no bit is counted and the counts are kept. Counting resumes from those counts when it is set again.
- R9: With checker-enable at 0 no bit or error is counted, whatever the count-enable holds.
- R10: A live counter that reaches all-ones stays there until it is cleared.
- R11: Address 1 holds the horizontal phase and address 2 holds the vertical height, each 6 bits wide and read/write, with higher bits reading 0. Unassigned addresses read 0, and writes to them or to snapshot addresses have no effect.
- R12: A command acts on the clock edge after the edge that captured its write, and the field clears itself so that writing it again repeats the command. A bit counted on the acting edge of command 1 or 3 lands in the freshly cleared live counter. The snapshot takes the count from before that edge.
- R13: The snapshot bit count is read at addresses 4 and up, and the error count at 8 and up, least significant DATA_W-bit word first. Read data is registered and appears one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for writes and reads |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data for reg_addr |
| bit_vld | input | 1 | A received bit is present this cycle |
| bit_rx | input | 1 | Received bit |
| bit_exp | input | 1 | Expected bit |

## Verification
The hardest state to reach from the ports is saturation, because a full-width counter needs 2^48 valid bits. The bench therefore builds the block with a 12-bit counter and 8-bit register words. It feeds more than 4095 mismatching bits so that both counters pin at all-ones, and it still reads each snapshot across two words. A second awkward case is a bit that arrives on the very edge where a snapshot-and-clear acts. The bench holds bit_vld high through the command write so that this bit must appear in the live count and not in the snapshot.

// File: rtl/ber_pkg.sv
package ber_pkg;
  localparam int ADDR_W  = 4;
  localparam int CMD_LSB = 3;

  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_CLEAR   = 2'd1,
    CMD_SNAP    = 2'd2,
    CMD_SNAPCLR = 2'd3
  } ber_cmd_e;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_HPH  = 4'd1;
  localparam logic [ADDR_W-1:0] A_VHT  = 4'd2;
  localparam logic [ADDR_W-1:0] A_SBIT = 4'd4;  // up to 4 words
  localparam logic [ADDR_W-1:0] A_SERR = 4'd8;  // up to 4 words
endpackage

// File: rtl/ber_regs.sv
module ber_regs
  import ber_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int COORD_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output ber_cmd_e           cmd,
  output logic               mon_en,
  output logic               chk_en,
  output logic               cnt_en,
  output logic [COORD_W-1:0] hph,
  output logic [COORD_W-1:0] vht
);
  logic unused_hi;
  assign unused_hi = ^wdata[DATA_W-1:COORD_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd    <= CMD_NONE;
      mon_en <= 1'b0;
      chk_en <= 1'b0;
      cnt_en <= 1'b0;
      hph    <= '0;
      vht    <= '0;
    end else begin
      cmd <= CMD_NONE;  // pulse: lasts one cycle
      if (wr) begin
        if (addr == A_CTRL) begin
          cmd    <= ber_cmd_e'(wdata[CMD_LSB+1:CMD_LSB]);
          cnt_en <= wdata[2];
          chk_en <= wdata[1];
          mon_en <= wdata[0];
        end
        if (addr == A_HPH) hph <= wdata[COORD_W-1:0];
        if (addr == A_VHT) vht <= wdata[COORD_W-1:0];
      end
    end
  end
endmodule

// File: rtl/ber_sat_counter.sv
module ber_sat_counter #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] base;
  logic [W-1:0] nxt;

  always_comb begin
    base = clr ? '0 : cnt;
    nxt  = (inc && !(&base)) ? base + W'(1) : base;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= nxt;
  end
endmodule

// File: rtl/ber_snapshot.sv
module ber_snapshot
  import ber_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  ber_cmd_e         cmd,
  input  logic [CNT_W-1:0] live_bits,
  input  logic [CNT_W-1:0] live_errs,
  output logic [CNT_W-1:0] snap_bits,
  output logic [CNT_W-1:0] snap_errs
);
  always_ff @(posedge clk) begin
    if (rst || cmd == CMD_CLEAR) begin
      snap_bits <= '0;
      snap_errs <= '0;
    end else if (cmd == CMD_SNAP || cmd == CMD_SNAPCLR) begin
      snap_bits <= live_bits;
      snap_errs <= live_errs;
    end
  end
endmodule

// File: rtl/ber_readback.sv
module ber_readback
  import ber_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 48,
  parameter int COORD_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               mon_en,
  input  logic               chk_en,
  input  logic               cnt_en,
  input  logic [COORD_W-1:0] hph,
  input  logic [COORD_W-1:0] vht,
  input  logic [CNT_W-1:0]   snap_bits,
  input  logic [CNT_W-1:0]   snap_errs,
  output logic [DATA_W-1:0]  rdata
);
  localparam int WORDS = (CNT_W + DATA_W - 1) / DATA_W;
  localparam int PAD_W = WORDS * DATA_W;

  logic [PAD_W-1:0]  pad_bits;
  logic [PAD_W-1:0]  pad_errs;
  logic [DATA_W-1:0] bit_w [WORDS];
  logic [DATA_W-1:0] err_w [WORDS];
  logic [DATA_W-1:0] sel;

  assign pad_bits = PAD_W'(snap_bits);
  assign pad_errs = PAD_W'(snap_errs);

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    assign bit_w[i] = pad_bits[i*DATA_W +: DATA_W];
    assign err_w[i] = pad_errs[i*DATA_W +: DATA_W];
  end

  always_comb begin
    sel = '0;
    if (addr == A_CTRL) sel = DATA_W'({cnt_en, chk_en, mon_en});
    if (addr == A_HPH)  sel = DATA_W'(hph);
    if (addr == A_VHT)  sel = DATA_W'(vht);
    for (int i = 0; i < WORDS; i++) begin
      if (addr == A_SBIT + ADDR_W'(i)) sel = bit_w[i];
      if (addr == A_SERR + ADDR_W'(i)) sel = err_w[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel;
  end
endmodule

// File: rtl/ber_snapshot_counter.sv
module ber_snapshot_counter
  import ber_pkg::*;
#(
  parameter int CNT_W   = 48,
  parameter int DATA_W  = 16,
  parameter int COORD_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              bit_vld,
  input  logic              bit_rx,
  input  logic              bit_exp
);
  ber_cmd_e           cmd_q;
  logic               mon_en, chk_en, cnt_en;
  logic [COORD_W-1:0] hph, vht;
  logic [CNT_W-1:0]   live [2];
  logic [CNT_W-1:0]   live_bits, live_errs;
  logic [CNT_W-1:0]   snap_bits, snap_errs;
  logic [1:0]         inc_v;
  logic               count_go, clear_live;

  ber_regs #(.DATA_W(DATA_W), .COORD_W(COORD_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .cmd(cmd_q), .mon_en(mon_en), .chk_en(chk_en), .cnt_en(cnt_en),
    .hph(hph), .vht(vht)
  );

  assign count_go   = bit_vld && chk_en && cnt_en;
  assign inc_v      = {count_go && (bit_rx != bit_exp), count_go};
  assign clear_live = (cmd_q == CMD_CLEAR) || (cmd_q == CMD_SNAPCLR);

  // index 0: bits checked, index 1: mismatches
  for (genvar k = 0; k < 2; k++) begin : g_cnt
    ber_sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .clr(clear_live), .inc(inc_v[k]), .cnt(live[k])
    );
  end

  assign live_bits = live[0];
  assign live_errs = live[1];

  ber_snapshot #(.CNT_W(CNT_W)) u_snap (
    .clk(clk), .rst(rst), .cmd(cmd_q),
    .live_bits(live_bits), .live_errs(live_errs),
    .snap_bits(snap_bits), .snap_errs(snap_errs)
  );

  ber_readback #(.DATA_W(DATA_W), .CNT_W(CNT_W), .COORD_W(COORD_W)) u_rb (
    .clk(clk), .rst(rst), .addr(reg_addr),
    .mon_en(mon_en), .chk_en(chk_en), .cnt_en(cnt_en),
    .hph(hph), .vht(vht), .snap_bits(snap_bits), .snap_errs(snap_errs),
    .rdata(reg_rdata)
  );
endmodule

// File: rtl/ber_chk.sv
module ber_chk
  import ber_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [1:0]        cmd,
  input logic              chk_en,
  input logic              cnt_en,
  input logic [CNT_W-1:0]  live_bits,
  input logic [CNT_W-1:0]  live_errs,
  input logic [CNT_W-1:0]  snap_bits,
  input logic [CNT_W-1:0]  snap_errs
);
  logic clr;
  assign clr = (cmd == CMD_CLEAR) || (cmd == CMD_SNAPCLR);

  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == A_CTRL) |=> cmd == CMD_NONE); // R12
  AST_ERR_BOUND: assert property (@(posedge clk) disable iff (rst)
    live_errs <= live_bits); // R7
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !clr) |=> ($stable(live_bits) && $stable(live_errs))); // R8
  AST_CHK_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!chk_en && !clr) |=> ($stable(live_bits) && $stable(live_errs))); // R9
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    cmd == CMD_NONE |=> ($stable(snap_bits) && $stable(snap_errs))); // R4
  AST_SNAP_COPY: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_SNAP || cmd == CMD_SNAPCLR)
      |=> (snap_bits == $past(live_bits) && snap_errs == $past(live_errs))); // R5
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
    cmd == CMD_CLEAR |=> (snap_bits == '0 && snap_errs == '0
                          && live_bits <= CNT_W'(1))); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    ((&live_bits) && !clr) |=> (&live_bits)); // R10
endmodule

bind ber_snapshot_counter ber_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .cmd(cmd_q),
  .chk_en(chk_en), .cnt_en(cnt_en), .live_bits(live_bits),
  .live_errs(live_errs), .snap_bits(snap_bits), .snap_errs(snap_errs)
);

// File: tb/test_ber_snapshot_counter.sv
module test_ber_snapshot_counter;
  localparam int CW = 12;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          bit_vld = 1'b0, bit_rx = 1'b0, bit_exp = 1'b0;

  int checks = 0, errors = 0;
  logic [2:0] en = 3'b000;  // {count-enable, checker-enable, monitor-enable}

  always #2.5 clk = ~clk;

  ber_snapshot_counter #(.CNT_W(CW), .DATA_W(DW)) i_ber_snapshot_counter (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bit_vld(bit_vld), .bit_rx(bit_rx), .bit_exp(bit_exp)
  );

  // {count, rx pattern, expected pattern}
  localparam logic [23:0] VEC [6] = '{
    {8'd20, 8'hAA, 8'hAA}, {8'd16, 8'hFF, 8'h00}, {8'd13, 8'h0F, 8'h0E},
    {8'd1,  8'h01, 8'h00}, {8'd40, 8'h5A, 8'hA5}, {8'd9,  8'hF0, 8'h70}
  };

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [DW-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic cmd(logic [1:0] c);
    wr(4'd0, DW'({c, en}));
    @(negedge clk);
  endtask

  task automatic rd(logic [3:0] a, output longint v);
    reg_addr = a;
    @(negedge clk);
    v = longint'(reg_rdata);
  endtask

  task automatic rd_cnt(logic [3:0] base, output longint v);
    longint lo, hi;
    rd(base, lo);
    rd(base + 4'd1, hi);
    v = (hi << DW) | lo;
  endtask

  task automatic send(int n, logic [7:0] rxp, logic [7:0] exq);
    for (int k = 0; k < n; k++) begin
      bit_vld = 1'b1; bit_rx = rxp[k % 8]; bit_exp = exq[k % 8];
      @(negedge clk);
    end
    bit_vld = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint v, b, e;
    int ne;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: every register reads 0 after reset
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v); chk("R1 reset read", v, 0);
    end

    // R2: control readback, command field and upper bits read 0
    wr(4'd0, 8'hE7); @(negedge clk);
    rd(4'd0, v); chk("R2 ctrl readback", v, 7);
    wr(4'd0, 8'h02); rd(4'd0, v); chk("R2 ctrl readback", v, 2);
    en = 3'b110;
    cmd(2'b01);

    // R7 + R13: vector walk, snapshot read least significant word first
    foreach (VEC[i]) begin
      cmd(2'b11);
      send(int'(VEC[i][23:16]), VEC[i][15:8], VEC[i][7:0]);
      cmd(2'b10);
      ne = 0;
      for (int k = 0; k < int'(VEC[i][23:16]); k++)
        if (VEC[i][8 + k % 8] != VEC[i][k % 8]) ne++;
      rd_cnt(4'd4, b); chk("R7 bit count", b, longint'(VEC[i][23:16]));
      rd_cnt(4'd8, e); chk("R7 error count", e, ne);
    end

    // R4: snapshot holds while the live count moves; R12: repeat re-triggers
    cmd(2'b01); send(5, 8'hFF, 8'h00); cmd(2'b10);
    send(7, 8'h00, 8'h00);
    rd_cnt(4'd4, b); chk("R4 snapshot held", b, 5);
    cmd(2'b10);
    rd_cnt(4'd4, b); chk("R12 re-trigger bits", b, 12);
    rd_cnt(4'd8, e); chk("R12 re-trigger errs", e, 5);

    // R6: command 0 touches nothing
    cmd(2'b00);
    rd_cnt(4'd4, b); chk("R6 snapshot kept", b, 12);
    cmd(2'b10);
    rd_cnt(4'd4, b); chk("R6 live kept", b, 12);

    // R3: clear zeroes snapshot and live counts
    cmd(2'b01);
    rd_cnt(4'd4, b); chk("R3 snap bits cleared", b, 0);
    rd_cnt(4'd8, e); chk("R3 snap errs cleared", e, 0);
    cmd(2'b10);
    rd_cnt(4'd4, b); chk("R3 live cleared", b, 0);

    // R5 + R12: snap-and-clear with a bit arriving on the acting edge
    send(5, 8'hFF, 8'h00);
    bit_vld = 1'b1; bit_rx = 1'b1; bit_exp = 1'b0;
    wr(4'd0, DW'({2'b11, en}));  // write edge counts bit 6
    @(negedge clk);               // acting edge: snap=6, live=1
    bit_vld = 1'b0;
    rd_cnt(4'd4, b); chk("R5 snapshot of live", b, 6);
    rd_cnt(4'd8, e); chk("R5 snapshot errs", e, 6);
    cmd(2'b10);
    rd_cnt(4'd4, b); chk("R12 edge bit in live", b, 1);
    rd_cnt(4'd8, e); chk("R12 edge err in live", e, 1);

    // R8: pause keeps counts, resume continues
    cmd(2'b01);
    send(4, 8'hFF, 8'h00);
    en = 3'b010; wr(4'd0, DW'(en));
    send(10, 8'hFF, 8'h00);
    en = 3'b110; wr(4'd0, DW'(en));
    send(3, 8'h00, 8'h00);
    cmd(2'b10);
    rd_cnt(4'd4, b); chk("R8 pause bits", b, 7);
    rd_cnt(4'd8, e); chk("R8 pause errs", e, 4);

    // R9: checker off stops counting even with count-enable set
    en = 3'b100; wr(4'd0, DW'(en));
    send(9, 8'hFF, 8'h00);
    cmd(2'b10);
    rd_cnt(4'd4, b); chk("R9 checker off bits", b, 7);
    rd_cnt(4'd8, e); chk("R9 checker off errs", e, 4);
    en = 3'b110;

    // R10: saturation at all-ones
    cmd(2'b01);
    send(4100, 8'hFF, 8'h00);
    cmd(2'b10);
    rd_cnt(4'd4, b); chk("R10 bits saturate", b, 4095);
    rd_cnt(4'd8, e); chk("R10 errs saturate", e, 4095);

    // R11: coordinates, unassigned and snapshot addresses
    wr(4'd1, 8'hFF); rd(4'd1, v); chk("R11 horizontal", v, 8'h3F);
    wr(4'd2, 8'h2A); rd(4'd2, v); chk("R11 vertical", v, 8'h2A);
    rd(4'd1, v); chk("R11 horizontal kept", v, 8'h3F);
    wr(4'd3, 8'h55); rd(4'd3, v); chk("R11 unassigned", v, 0);
    wr(4'd4, 8'h00); rd(4'd4, v); chk("R11 snapshot write ignored", v, 8'hFF);
    rd(4'd0, v); chk("R11 ctrl untouched", v, 6);

    // R1: reset again clears all state
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    rd(4'd1, v); chk("R1 reset coord", v, 0);
    rd_cnt(4'd8, e); chk("R1 reset snapshot", e, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule